// File: doc/BRIEF.md
# Serially Programmed Multichannel Pulse Delay

This block gives each of a set of trigger inputs its own programmable delay. When a channel sees a rising edge on its trigger input, it waits a fixed base time plus its 4-bit code times a step time. It then drives one output pulse of fixed width. All times count system clock cycles, and the base, step and width are parameters. After a trigger, the channel ignores further edges until its output pulse has ended.

The delay codes are written through a slow serial control port. Its inputs are an active-low select, a control clock, a data input, and a data output that carries the bits leaving the end of the chain, so several units can be cascaded or the loaded pattern read back. The control inputs are synchronized into the system clock domain and the control clock edge is found by sampling. The control clock must therefore run at no more than a quarter of the system clock rate. Shifted bits take effect as a group only when select is released. An active-low clear line forces every active code to zero at once.

Top module: `serial_pulse_delay`

## Requirements
- R1: After a rising edge on `trig_in[k]` is sampled at clock edge E0 (input seen low at the edge before), `pulse_out[k]` goes high after edge E0 + BASE_CYC + code[k]*STEP_CYC, with the defaults BASE_CYC = 10 and STEP_CYC = 2.
- R2: Each output pulse lasts exactly WIDTH_CYC (default 20) cycles, whether the trigger input was high for one cycle or for longer than the whole delay.
- R3: While `cs_n` is low, each rising edge of `sclk` shifts `sdi` into bit 0 of a 64-bit chain. Bits move toward bit 63, most significant bit first. Channel 15's code is sent first, and channel k's code sits in chain bits 4k+3..4k.
- R4: Shifted bits do not change any active code while `cs_n` stays low. All codes take their new values when `cs_n` rises.
- R5: While `clr_n` is low every active code is zero. This holds without waiting for a clock edge, and it wins over a latch from a `cs_n` rise in the same cycle.
- R6: `sdo` always shows chain bit 63, so while a new word is shifted in, the previous contents come out most significant bit first.
- R7: While `cs_n` is high, `sclk` edges neither move the chain nor change the active codes.
- R8: A rising trigger edge that arrives while its channel is counting a delay or driving a pulse is ignored, and the channel rearms once its pulse has ended.
- R9: A delay already counting runs to the end with the code it started with, even if a new code is latched during it.
- R10: After reset all outputs are low, `sdo` is 0 and every code is zero, so each channel delays by BASE_CYC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the whole block |
| clr_n | input | 1 | Active-low clear of all active delay codes |
| cs_n | input | 1 | Active-low serial select; its rising edge latches the chain |
| sclk | input | 1 | Serial control clock, at most a quarter of the `clk` rate |
| sdi | input | 1 | Serial data into the chain |
| sdo | output | 1 | Serial data out of the end of the chain |
| trig_in | input | NUM_CH | Per-channel trigger inputs, synchronous to `clk` |
| pulse_out | output | NUM_CH | Per-channel delayed output pulses |

## Verification
The bench drives a retrigger while a channel is counting. A design that restarts on that edge would show a late or a second pulse. It also latches new codes in the middle of a delay, where a design that reads the live code would shift the pulse. It applies a clear in the same cycles as a `cs_n` release, where a design that lets the latch win would leave nonzero codes. Control clock edges with select high must leave both the read-back chain and the measured delays untouched. A one-cycle trigger must still give a full-width pulse, and a pulse cut short by the input would show up as a width error.

// File: rtl/spd_pkg.sv
package spd_pkg;
   typedef enum logic [1:0] {
      CH_IDLE  = 2'd0,
      CH_WAIT  = 2'd1,
      CH_PULSE = 2'd2
   } ch_state_e;

   function automatic int unsigned spd_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/spd_sync_vec.sv
module spd_sync_vec #(
   parameter int unsigned   W       = 1,
   parameter int unsigned   STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("spd_sync_vec: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic [W-1:0] st_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st_q <= RST_VAL;
         else        st_q <= d;
      end
      assign q = st_q;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] st_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st_q <= {STAGES{RST_VAL}};
         else        st_q <= {st_q[STAGES-2:0], d};
      end
      assign q = st_q[STAGES-1];
   end
endmodule

// File: rtl/spd_ctl_front.sv
module spd_ctl_front #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sclk,
   input  logic sdi,
   output logic shift_en,
   output logic shift_bit,
   output logic latch_en
);
   logic [2:0] raw_v;
   logic [2:0] sync_v;
   logic       cs_s, ck_s;
   logic       cs_prev_q, ck_prev_q;

   assign raw_v = {cs_n, sclk, sdi};

   spd_sync_vec #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_v),
      .q     (sync_v)
   );

   assign cs_s      = sync_v[2];
   assign ck_s      = sync_v[1];
   assign shift_bit = sync_v[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_prev_q <= 1'b1;
         ck_prev_q <= 1'b0;
      end else begin
         cs_prev_q <= cs_s;
         ck_prev_q <= ck_s;
      end
   end

   assign shift_en = ck_s & ~ck_prev_q & ~cs_s;
   assign latch_en = cs_s & ~cs_prev_q;

   AST_SHIFT_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> !shift_en);                                      // R3
   AST_LATCH_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      latch_en |=> !latch_en);                                      // R4
endmodule

// File: rtl/spd_shift_chain.sv
module spd_shift_chain #(
   parameter int unsigned NUM_CH = 16,
   parameter int unsigned CODE_W = 4,
   localparam int unsigned LEN   = NUM_CH * CODE_W
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr_n,
   input  logic           shift_en,
   input  logic           shift_bit,
   input  logic           latch_en,
   output logic           sdo,
   output logic [LEN-1:0] codes
);
   logic [LEN-1:0] sr_q;
   logic [LEN-1:0] codes_q;
   logic           code_rst_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sr_q <= '0;
      else if (shift_en) sr_q <= {sr_q[LEN-2:0], shift_bit};
   end

   // clear acts without a clock edge, so it overrides any latch
   assign code_rst_n = rst_n & clr_n;

   always_ff @(posedge clk or negedge code_rst_n) begin
      if (!code_rst_n)   codes_q <= '0;
      else if (latch_en) codes_q <= sr_q;
   end

   assign sdo   = sr_q[LEN-1];
   assign codes = codes_q;

   AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(sr_q));                                 // R7
   AST_CODES_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      !latch_en |=> $stable(codes_q));                              // R4
   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |-> (codes_q == '0));                                  // R5
   AST_LATCH_COPIES: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      (latch_en && clr_n) |=> (codes_q == $past(sr_q)));            // R4
endmodule

// File: rtl/spd_channel.sv
module spd_channel
   import spd_pkg::*;
#(
   parameter int unsigned CODE_W    = 4,
   parameter int unsigned BASE_CYC  = 10,
   parameter int unsigned STEP_CYC  = 2,
   parameter int unsigned WIDTH_CYC = 20,
   localparam int unsigned MAX_DLY  = BASE_CYC + ((2 ** CODE_W) - 1) * STEP_CYC,
   localparam int unsigned CNT_W    = $clog2(spd_max(MAX_DLY, WIDTH_CYC) + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code,
   input  logic              trig,
   output logic              pulse_out
);
   ch_state_e        state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             trig_d_q;
   logic             rise;
   logic [CNT_W-1:0] load_val;

   assign rise     = trig & ~trig_d_q;
   assign load_val = CNT_W'(BASE_CYC) + CNT_W'(code) * CNT_W'(STEP_CYC) - CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= CH_IDLE;
         cnt_q    <= '0;
         trig_d_q <= 1'b0;
      end else begin
         trig_d_q <= trig;
         unique case (state_q)
            CH_IDLE: begin
               if (rise) begin
                  state_q <= CH_WAIT;
                  cnt_q   <= load_val;
               end
            end
            CH_WAIT: begin
               if (cnt_q == '0) begin
                  state_q <= CH_PULSE;
                  cnt_q   <= CNT_W'(WIDTH_CYC - 1);
               end else begin
                  cnt_q   <= cnt_q - CNT_W'(1);
               end
            end
            CH_PULSE: begin
               if (cnt_q == '0) state_q <= CH_IDLE;
               else             cnt_q   <= cnt_q - CNT_W'(1);
            end
            default: state_q <= CH_IDLE;
         endcase
      end
   end

   assign pulse_out = (state_q == CH_PULSE);

   AST_RISE_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_out) |-> ($past(state_q) == CH_WAIT));             // R1
   AST_PULSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CH_PULSE && cnt_q != '0) |=> pulse_out);           // R2
   AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CH_WAIT && cnt_q != '0) |=>
         (state_q == CH_WAIT && cnt_q == $past(cnt_q) - CNT_W'(1))); // R8
   AST_IDLE_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != CH_IDLE) |=>
         (state_q != CH_IDLE || $past(state_q) == CH_PULSE));        // R9
endmodule

// File: rtl/serial_pulse_delay.sv
module serial_pulse_delay #(
   parameter int unsigned NUM_CH         = 16,
   parameter int unsigned CODE_W         = 4,
   parameter int unsigned BASE_CYC       = 10,
   parameter int unsigned STEP_CYC       = 2,
   parameter int unsigned WIDTH_CYC      = 20,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned IN_SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              sdi,
   output logic              sdo,
   input  logic [NUM_CH-1:0] trig_in,
   output logic [NUM_CH-1:0] pulse_out
);
   localparam int unsigned LEN = NUM_CH * CODE_W;

   if (NUM_CH < 1)      begin : g_bad_ch    $error("NUM_CH must be at least 1");      end
   if (CODE_W < 1)      begin : g_bad_code  $error("CODE_W must be at least 1");      end
   if (BASE_CYC < 1)    begin : g_bad_base  $error("BASE_CYC must be at least 1");    end
   if (WIDTH_CYC < 1)   begin : g_bad_width $error("WIDTH_CYC must be at least 1");   end
   if (SYNC_STAGES < 2) begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end

   logic           shift_en, shift_bit, latch_en;
   logic [LEN-1:0] codes;
   logic [NUM_CH-1:0] trig_s;

   spd_ctl_front #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_front (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cs_n),
      .sclk      (sclk),
      .sdi       (sdi),
      .shift_en  (shift_en),
      .shift_bit (shift_bit),
      .latch_en  (latch_en)
   );

   spd_shift_chain #(
      .NUM_CH (NUM_CH),
      .CODE_W (CODE_W)
   ) u_chain (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_n     (clr_n),
      .shift_en  (shift_en),
      .shift_bit (shift_bit),
      .latch_en  (latch_en),
      .sdo       (sdo),
      .codes     (codes)
   );

   if (IN_SYNC_STAGES == 0) begin : g_trig_direct
      assign trig_s = trig_in;
   end else begin : g_trig_sync
      spd_sync_vec #(
         .W       (NUM_CH),
         .STAGES  (IN_SYNC_STAGES),
         .RST_VAL ('0)
      ) u_trig_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (trig_in),
         .q     (trig_s)
      );
   end

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      spd_channel #(
         .CODE_W    (CODE_W),
         .BASE_CYC  (BASE_CYC),
         .STEP_CYC  (STEP_CYC),
         .WIDTH_CYC (WIDTH_CYC)
      ) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .code      (codes[k*CODE_W +: CODE_W]),
         .trig      (trig_s[k]),
         .pulse_out (pulse_out[k])
      );
   end

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (pulse_out == '0));                                 // R10
endmodule

// File: tb/tb_serial_pulse_delay.sv
module tb_serial_pulse_delay;
   localparam int NCH   = 16;
   localparam int BASE  = 10;
   localparam int STEP  = 2;
   localparam int WID   = 20;
   localparam int LIM   = 80;

   localparam logic [63:0] VEC [4] = '{
      64'h0123_4567_89AB_CDEF,
      64'hFEDC_BA98_7654_3210,
      64'hF0F0_0F0F_A5A5_5A5A,
      64'h8000_0000_0000_0001
   };
   localparam logic [63:0] W4 = 64'h3C96_1E0F_7B2D_84A5;
   localparam logic [63:0] W5 = 64'h5A5A_C3C3_E1E1_7878;

   logic clk = 1'b0, rst_n = 1'b0, clr_n = 1'b1;
   logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
   logic sdo;
   logic [NCH-1:0] trig_in = '0;
   logic [NCH-1:0] pulse_out;

   int n_vec = 0;
   int n_bad = 0;
   logic [63:0] rb;

   always #4 clk = ~clk;

   serial_pulse_delay dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_n     (clr_n),
      .cs_n      (cs_n),
      .sclk      (sclk),
      .sdi       (sdi),
      .sdo       (sdo),
      .trig_in   (trig_in),
      .pulse_out (pulse_out)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk64(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   // shift a word MSB first, capturing sdo before each control clock rise
   task automatic shift_word(input logic [63:0] w, input bit rel, output logic [63:0] got);
      @(negedge clk); cs_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 63; i >= 0; i--) begin
         sdi = w[i];
         repeat (4) @(negedge clk);
         got[i] = sdo;
         sclk = 1'b1;
         repeat (4) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (4) @(negedge clk);
      if (rel) begin
         cs_n = 1'b1;
         repeat (8) @(negedge clk);
      end
   endtask

   // fire all channels and measure delay, width and pulse count per channel
   task automatic fire_all(input int hold, input bit retrig, input int rel_at,
                           input logic [63:0] cw, input string req);
      int first [NCH];
      int wid   [NCH];
      int npul  [NCH];
      bit prev  [NCH];
      for (int c = 0; c < NCH; c++) begin
         first[c] = -1; wid[c] = 0; npul[c] = 0; prev[c] = 1'b0;
      end
      @(negedge clk); trig_in = '1;
      for (int n = 1; n <= LIM; n++) begin
         @(posedge clk); @(negedge clk);
         for (int c = 0; c < NCH; c++) begin
            if (pulse_out[c]) begin
               if (!prev[c]) begin
                  npul[c]++;
                  if (first[c] < 0) first[c] = n - 1;
               end
               wid[c]++;
            end
            prev[c] = pulse_out[c];
         end
         if (n == hold) trig_in = '0;
         if (retrig && n == 3) trig_in = '0;
         if (retrig && n == 5) trig_in = '1;
         if (rel_at != 0 && n == rel_at) cs_n = 1'b1;
      end
      trig_in = '0;
      repeat (3) @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
         int exp_d;
         exp_d = BASE + int'(cw[4*c +: 4]) * STEP;
         chk(first[c] == exp_d, $sformatf("%s delay ch%0d", req, c), first[c], exp_d);
         chk(wid[c] == WID, $sformatf("%s width ch%0d", req, c), wid[c], WID);
         chk(npul[c] == 1, $sformatf("%s pulse count ch%0d", req, c), npul[c], 1);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      chk(pulse_out == '0, "R10 outputs low", int'(pulse_out), 0);
      chk(sdo == 1'b0, "R10 sdo low", int'(sdo), 0);
      fire_all(0, 1'b0, 0, 64'h0, "R10 zero codes");

      // table walk: R1 delay law, R3 chain layout, R6 readback of previous word
      for (int v = 0; v < 4; v++) begin
         shift_word(VEC[v], 1'b1, rb);
         if (v > 0) chk64("R6 readback", rb, VEC[v-1]);
         fire_all(0, 1'b0, 0, VEC[v], "R1 R3 table");
      end

      // R2: one-cycle trigger still gives full width
      fire_all(1, 1'b0, 0, VEC[3], "R2 short trigger");

      // R8: retrigger during delay ignored, then rearm
      fire_all(0, 1'b1, 0, VEC[3], "R8 retrigger");
      fire_all(0, 1'b0, 0, VEC[3], "R8 rearm");

      // R4: shifted but unlatched codes have no effect
      shift_word(W4, 1'b0, rb);
      chk64("R6 readback", rb, VEC[3]);
      fire_all(0, 1'b0, 0, VEC[3], "R4 before latch");
      @(negedge clk); cs_n = 1'b1;
      repeat (8) @(negedge clk);
      fire_all(0, 1'b0, 0, W4, "R4 after latch");

      // R7: control clocks with select high are ignored
      sdi = 1'b1;
      for (int i = 0; i < 16; i++) begin
         repeat (4) @(negedge clk); sclk = 1'b1;
         repeat (4) @(negedge clk); sclk = 1'b0;
      end
      sdi = 1'b0;
      repeat (4) @(negedge clk);
      fire_all(0, 1'b0, 0, W4, "R7 codes");
      shift_word(W5, 1'b0, rb);
      chk64("R7 chain", rb, W4);

      // R9: latch in the middle of a delay keeps the old code
      fire_all(0, 1'b0, 2, W4, "R9 in flight");
      repeat (4) @(negedge clk);
      fire_all(0, 1'b0, 0, W5, "R9 next edge");

      // R5: clear forces zero codes
      @(negedge clk); clr_n = 1'b0;
      repeat (3) @(negedge clk); clr_n = 1'b1;
      repeat (2) @(negedge clk);
      fire_all(0, 1'b0, 0, 64'h0, "R5 clear");

      // R5: clear wins over a latch in the same cycles
      shift_word(VEC[0], 1'b0, rb);
      @(negedge clk); cs_n = 1'b1; clr_n = 1'b0;
      repeat (10) @(negedge clk); clr_n = 1'b1;
      repeat (4) @(negedge clk);
      fire_all(0, 1'b0, 0, 64'h0, "R5 clear over latch");

      finish_run();
   end
endmodule